// File: doc/BRIEF.md
# Forced disk-change flag logic

This block keeps one sticky "force change" flag per floppy drive and folds those flags into the disk-change bit that the floppy controller reports on its digital input register read path. Firmware can raise a flag by writing a one to the flag's bit in a small read/write register. Firmware cannot lower a flag. A flag drops only when the head-step line pulses while its own drive is selected. Because of this, a drive that has been forced keeps reporting "media changed" until the drive has actually been stepped.

The step, drive-select and disk-change inputs arrive from the drive cable as active-low levels. Each is brought into the clock domain through a synchronizer chain. The synchronized step level is then reduced to a single-cycle pulse, so that one step clears a flag at most once however long the step is held. The status output is the OR of the synchronized disk-change input and the flags of every selected drive. It is the value that sits at bit 7 of the digital input register.

Top module: `fdc_force_chg`

## Requirements
- R1: While `rst_n` is low and right after it is released, both flags are set and `reg_rdata` reads 0x03.
- R2: A write (`reg_wr_en` high for one cycle) with `reg_wdata[i]` = 1 sets flag i. A write with `reg_wdata[i]` = 0 leaves flag i unchanged, so software cannot clear a flag.
- R3: `reg_rdata[7:2]` always reads 0, and writes to those bits have no effect.
- R4: Flag i is cleared by a step pulse (`step_n` going low) while drive i is selected (`drive_sel_n[i]` low). The flag of an unselected drive is not touched. If both drives are selected, both flags clear.
- R5: A step line that stays low clears a flag only once. A flag set by software while the step is still held stays set.
- R6: When a software set and a step clear of the same flag land in the same clock cycle, the flag ends up set.
- R7: `dir_chg` is high when `disk_chg_n` is low, or when any selected drive's flag is set. Otherwise it is low.
- R8: Flag i reads back at `reg_rdata[i]` (bit 0 for drive 0, bit 1 for drive 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset of the standby domain |
| reg_wr_en | input | 1 | One-cycle write strobe for the flag register |
| reg_wdata | input | 8 | Write data; a one in bit i sets flag i |
| reg_rdata | output | 8 | Flag register read value |
| step_n | input | 1 | Head-step line from the drive interface, active low |
| drive_sel_n | input | 2 | Drive select lines, active low, bit i for drive i |
| disk_chg_n | input | 1 | Disk-change line from the drive, active low |
| dir_chg | output | 1 | Disk-change status for bit 7 of the digital input register |

## Verification
The bench aims a software set at the exact cycle in which a step pulse clears the same flag. A design that lets the clear win would read back a zero there. It also holds the step line low across a software set, which exposes a level-sensitive clear: that design would wipe the freshly set flag again. Steps taken with a drive unselected, or with both drives selected, catch a design that ignores the select or mixes up drive indices. Writes of zeros and of the upper bits catch a design in which software can clear a flag or store unused bits.

// File: rtl/fdc_fc_pkg.sv
package fdc_fc_pkg;
    // default geometry of the flag register
    localparam int unsigned FC_DEF_DRIVES = 2;
    localparam int unsigned FC_DEF_REG_W  = 8;
    localparam int unsigned FC_DEF_SYNC   = 2;

    // idle level of a cable line seen by a synchronizer
    typedef enum logic {
        FC_IDLE_LOW  = 1'b0,
        FC_IDLE_HIGH = 1'b1
    } fc_idle_e;
endpackage

// File: rtl/fc_sync.sv
module fc_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] IDLE  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_st_t;

    sync_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.chain <= {STAGES{IDLE}};
        else        s_q       <= s_d;
    end

    assign dout = s_q.chain[STAGES-1];
endmodule

// File: rtl/fc_edge.sv
module fc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,     // active-high synchronized level
    output logic pulse    // one cycle on each rising level
);
    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t e_d, e_q;

    always_comb begin
        e_d      = e_q;
        e_d.prev = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q.prev <= 1'b0;
        else        e_q      <= e_d;
    end

    assign pulse = lvl & ~e_q.prev;
endmodule

// File: rtl/fc_flag_bank.sv
module fc_flag_bank #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_req,
    input  logic [N-1:0] clr_req,
    output logic [N-1:0] flags
);
    typedef struct packed {
        logic [N-1:0] flag;
    } bank_st_t;

    bank_st_t b_d, b_q;
    logic [N-1:0] nxt;

    // per drive: a set beats a same-cycle clear
    for (genvar g = 0; g < N; g++) begin : g_drv
        assign nxt[g] = set_req[g] | (b_q.flag[g] & ~clr_req[g]);
    end

    always_comb begin
        b_d      = b_q;
        b_d.flag = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q.flag <= '1;
        else        b_q      <= b_d;
    end

    assign flags = b_q.flag;
endmodule

// File: rtl/fdc_force_chg.sv
module fdc_force_chg
    import fdc_fc_pkg::*;
#(
    parameter int unsigned NUM_DRV = FC_DEF_DRIVES,
    parameter int unsigned REG_W   = FC_DEF_REG_W,
    parameter int unsigned SYNC    = FC_DEF_SYNC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               step_n,
    input  logic [NUM_DRV-1:0] drive_sel_n,
    input  logic               disk_chg_n,
    output logic               dir_chg
);
    localparam int unsigned LINES = NUM_DRV + 2;
    localparam logic [LINES-1:0] LINE_IDLE = {LINES{FC_IDLE_HIGH}};

    typedef struct packed {
        logic [NUM_DRV-1:0] set_req;
        logic [NUM_DRV-1:0] clr_req;
        logic               status;
    } top_cmb_t;

    logic [LINES-1:0]   raw_lines;
    logic [LINES-1:0]   sync_lines;
    logic               step_act;
    logic               step_pulse;
    logic [NUM_DRV-1:0] sel_act;
    logic               chg_act;
    logic [NUM_DRV-1:0] flags;
    top_cmb_t           c_d;

    assign raw_lines = {disk_chg_n, drive_sel_n, step_n};

    fc_sync #(.W(LINES), .STAGES(SYNC), .IDLE(LINE_IDLE)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_lines),
        .dout (sync_lines)
    );

    assign step_act = ~sync_lines[0];
    assign sel_act  = ~sync_lines[NUM_DRV:1];
    assign chg_act  = ~sync_lines[NUM_DRV+1];

    fc_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (step_act),
        .pulse(step_pulse)
    );

    always_comb begin
        c_d         = '0;
        c_d.set_req = reg_wr_en ? reg_wdata[NUM_DRV-1:0] : '0;
        c_d.clr_req = {NUM_DRV{step_pulse}} & sel_act;
        c_d.status  = chg_act | (|(sel_act & flags));
    end

    fc_flag_bank #(.N(NUM_DRV)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_req(c_d.set_req),
        .clr_req(c_d.clr_req),
        .flags  (flags)
    );

    assign reg_rdata = {{(REG_W-NUM_DRV){1'b0}}, flags};
    assign dir_chg   = c_d.status;
endmodule

// File: rtl/fc_chk.sv
module fc_chk #(
    parameter int unsigned NUM_DRV = 2,
    parameter int unsigned REG_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr_en,
    input logic [REG_W-1:0]   reg_wdata,
    input logic [REG_W-1:0]   reg_rdata,
    input logic               dir_chg,
    input logic               step_pulse,
    input logic [NUM_DRV-1:0] sel_act,
    input logic               chg_act
);
    // R2
    wr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> ((reg_rdata[NUM_DRV-1:0] & $past(reg_wdata[NUM_DRV-1:0]))
                       == $past(reg_wdata[NUM_DRV-1:0])));

    // R3
    hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-1:NUM_DRV] == '0);

    for (genvar g = 0; g < NUM_DRV; g++) begin : g_fall
        // R4
        fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(reg_rdata[g]) |-> $past(step_pulse && sel_act[g]));
        // R6
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr_en && reg_wdata[g] && step_pulse && sel_act[g]) |=> reg_rdata[g]);
    end

    // R5
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse |=> !step_pulse);

    // R7
    chg_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_act |-> dir_chg);
endmodule

bind fdc_force_chg fc_chk #(.NUM_DRV(NUM_DRV), .REG_W(REG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .dir_chg   (dir_chg),
    .step_pulse(step_pulse),
    .sel_act   (sel_act),
    .chg_act   (chg_act)
);

// File: tb/sim_fdc_force_chg.sv
module sim_fdc_force_chg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       step_n = 1'b1;
    logic [1:0] drive_sel_n = 2'b11;
    logic       disk_chg_n = 1'b1;
    logic       dir_chg;

    int unsigned checks = 0;
    int unsigned fails  = 0;
    logic [1:0]  m_flags = 2'b11;

    always #10 clk = ~clk;

    fdc_force_chg u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr_en  (reg_wr_en),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .step_n     (step_n),
        .drive_sel_n(drive_sel_n),
        .disk_chg_n (disk_chg_n),
        .dir_chg    (dir_chg)
    );

    function automatic logic exp_stat();
        return (~disk_chg_n) | (|(~drive_sel_n & m_flags));
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_all(input string req);
        chk(req, reg_rdata, {6'b0, m_flags});
        chk(req, {7'b0, dir_chg}, {7'b0, exp_stat()});
    endtask

    task automatic do_write(input logic [7:0] v);
        reg_wr_en = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_wdata = 8'h00;
        m_flags   = m_flags | v[1:0];
        settle(1);
    endtask

    task automatic do_step();
        step_n = 1'b0;
        settle(4);
        m_flags = m_flags & drive_sel_n;
        step_n = 1'b1;
        settle(4);
    endtask

    task automatic set_lines(input logic [1:0] sel, input logic chg);
        drive_sel_n = sel;
        disk_chg_n  = chg;
        settle(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h0000_5eed));
        settle(3);
        // R1 during reset and after release
        chk("R1", reg_rdata, 8'h03);
        rst_n = 1'b1;
        settle(2);
        chk("R1", reg_rdata, 8'h03);
        chk("R7", {7'b0, dir_chg}, 8'h00);

        // R7 R8: selecting drive 0 shows its forced flag
        set_lines(2'b10, 1'b1);
        check_all("R7");
        chk("R8", reg_rdata, 8'h03);

        // R4: step with drive 0 selected clears only flag 0
        do_step();
        chk("R4", reg_rdata, 8'h02);
        check_all("R7");

        // R2: writing zeros does not clear flag 1
        do_write(8'h00);
        chk("R2", reg_rdata, 8'h02);

        // R3: upper bits ignored
        do_write(8'hFC);
        chk("R3", reg_rdata, 8'h02);

        // R4: step with nothing selected changes nothing
        set_lines(2'b11, 1'b1);
        do_step();
        chk("R4", reg_rdata, 8'h02);

        // R7: external disk change alone drives the status
        set_lines(2'b11, 1'b0);
        chk("R7", {7'b0, dir_chg}, 8'h01);
        set_lines(2'b11, 1'b1);

        // R4: both selected, both cleared
        do_write(8'h01);
        chk("R2", reg_rdata, 8'h03);
        set_lines(2'b00, 1'b1);
        do_step();
        chk("R4", reg_rdata, 8'h00);
        chk("R7", {7'b0, dir_chg}, 8'h00);

        // R5: held step clears once; a set during the hold survives
        do_write(8'h01);
        set_lines(2'b10, 1'b1);
        step_n = 1'b0;
        settle(4);
        chk("R5", reg_rdata, 8'h00);
        do_write(8'h01);
        settle(4);
        chk("R5", reg_rdata, 8'h01);
        step_n = 1'b1;
        settle(4);
        chk("R5", reg_rdata, 8'h01);

        // R6: set lands in the same cycle as the clear pulse
        do_step();
        chk("R6", reg_rdata, 8'h00);
        step_n = 1'b0;
        settle(2);
        reg_wr_en = 1'b1;
        reg_wdata = 8'h01;
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_wdata = 8'h00;
        settle(3);
        chk("R6", reg_rdata, 8'h01);
        step_n = 1'b1;
        settle(4);
        m_flags = 2'b01;
        check_all("R6");

        // random mix
        for (int k = 0; k < 400; k++) begin
            case ($urandom_range(0, 3))
                0: do_write(8'($urandom()));
                1: set_lines(2'($urandom()), disk_chg_n);
                2: set_lines(drive_sel_n, 1'($urandom()));
                default: do_step();
            endcase
            check_all("R7");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule